// File: doc/BRIEF.md
# UART interrupt identification logic

This block ranks the interrupt causes of a 16550-style serial port and presents the result as an identification byte plus one interrupt line. It takes the current interrupt-enable bits and the receive-side line status. It also takes the receive FIFO fill count and threshold, the character-timeout flag and the modem delta bits. The block keeps the transmitter-empty pending flag itself. That flag is driven by three strobes: a write to the transmit holding register, a read of the identification byte, and a write to the enable register. A rising edge of the holding-register-empty status also drives it.

The pending flag is a two-state machine: `THR_QUIET` means no transmit-empty interrupt is owed, and `THR_ARMED` means one is owed. The transitions are as follows. Transmit write: any state goes to `THR_QUIET`. Enable re-sample, when a write to the enable register flips the transmit-empty enable: the flag goes to `THR_ARMED` if the new enable is 1 and the holding register is empty, and to `THR_QUIET` otherwise. Empty-edge arm: on a 0-to-1 change of the empty status, the flag goes to `THR_ARMED`. Acknowledge-by-read, a read of the identification byte while it reports code 0x2: `THR_ARMED` goes to `THR_QUIET`. When several of these events fall in the same cycle, they take effect in the order just listed, and the first one wins.

Both the identification byte and the interrupt line are registered. They reflect the inputs and the flag's next state as sampled at the preceding clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01 and `irq` is low.
- R2: Priority from highest to lowest is line status, character timeout, receive data, transmitter empty, modem status; the lower-nibble codes are 0x6, 0xC, 0x4, 0x2, 0x0, and 0x1 when nothing is pending.
- R3: The line-status source is active when `ien[2]` is 1 and any of `line_stat[4:1]` (overrun, parity, framing, break) is 1.
- R4: The timeout source is active when `rx_timeout` is 1 and the receive-data enable `ien[0]` is 1; it has no enable of its own.
- R5: The receive-data source needs `ien[0]` and data ready `line_stat[0]`; when `fifo_en` is 1 it also needs `rx_count >= rx_trig`.
- R6: The modem source is active when `ien[3]` is 1 and any bit of `msr_delta` is 1.
- R7: A 0-to-1 change of `line_stat[5]` (holding register empty) arms the transmit-empty flag, reported as code 0x2 when `ien[1]` is 1.
- R8: `thr_wr` clears the flag and takes precedence over every other flag event in the same cycle.
- R9: `iir_rd` clears the flag only while the registered code is 0x2; a read while another code is shown leaves the flag armed.
- R10: `ier_wr` with `ier_new_tx` different from `ien[1]` sets the flag to `ier_new_tx & line_stat[5]`; with no change of that bit it leaves the flag alone.
- R11: Identification bits 7:6 are 11 when `fifo_en` is 1 and 00 otherwise; bits 5:4 are 0.
- R12: `irq` is 1 exactly when the registered code is not 0x1, and both update one clock edge after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien | input | 4 | Enables: 0 receive data/timeout, 1 transmit empty, 2 line status, 3 modem |
| line_stat | input | 6 | 0 data ready, 1-4 error bits, 5 holding register empty |
| fifo_en | input | 1 | FIFO mode on |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification byte read strobe |
| ier_wr | input | 1 | Enable register write strobe |
| ier_new_tx | input | 1 | Value written to the transmit-empty enable bit |
| iir_q | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The only hidden state is the transmit-empty flag. A flag stuck in the wrong state shows up at the next edge as a missing or surplus code 0x2, provided no higher source is active and `ien[1]` is set. For that reason each flag test first removes every higher source and then checks one cycle after the strobe. The bench also checks the read that must not acknowledge while a higher code is shown, and the same-cycle conflict between a transmit write and an empty edge. A ranking or gating fault shows up in the very next registered byte.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_THRE    = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    typedef enum logic {
        THR_QUIET = 1'b0,
        THR_ARMED = 1'b1
    } thr_state_e;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    localparam int ST_DR    = 0;
    localparam int ST_THRE  = 5;
endpackage

// File: rtl/uart_irq_thr_track.sv
module uart_irq_thr_track
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thre,
    input  logic en_tx,
    input  logic ier_wr,
    input  logic ier_new_tx,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic shown_thre,
    output logic pend_next
);
    thr_state_e state_q, state_d;
    logic       thre_d;
    logic       rise, toggle, ack;

    assign rise   = thre & ~thre_d;
    assign toggle = ier_wr & (ier_new_tx ^ en_tx);
    assign ack    = iir_rd & shown_thre;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= THR_QUIET;
            thre_d  <= 1'b1;
        end else begin
            state_q <= state_d;
            thre_d  <= thre;
        end
    end

    // transitions, first listed event wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_QUIET: begin
                if (thr_wr)
                    state_d = THR_QUIET;
                else if (toggle)
                    state_d = (ier_new_tx & thre) ? THR_ARMED : THR_QUIET;
                else if (rise)
                    state_d = THR_ARMED;
            end
            THR_ARMED: begin
                if (thr_wr)
                    state_d = THR_QUIET;
                else if (toggle)
                    state_d = (ier_new_tx & thre) ? THR_ARMED : THR_QUIET;
                else if (rise)
                    state_d = THR_ARMED;
                else if (ack)
                    state_d = THR_QUIET;
            end
            default: state_d = THR_QUIET;
        endcase
    end

    // output
    always_comb begin
        pend_next = (state_d == THR_ARMED);
    end
endmodule

// File: rtl/uart_irq_rx_qual.sv
module uart_irq_rx_qual #(
    parameter int CNT_W = 5
) (
    input  logic             fifo_en,
    input  logic             ready,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             avail
);
    logic level_ok;

    assign level_ok = (count >= trig);
    assign avail    = ready & (~fifo_en | level_ok);
endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
    import uart_irq_pkg::*;
(
    input  logic [3:0] ien,
    input  logic [4:1] errs,
    input  logic       timeout,
    input  logic       rx_avail,
    input  logic       thr_pend,
    input  logic [3:0] msr_delta,
    output irq_id_e    id
);
    logic line_hit, tmo_hit, rx_hit, tx_hit, ms_hit;

    assign line_hit = ien[EN_LINE]  & (|errs);
    assign tmo_hit  = ien[EN_RX]    & timeout;
    assign rx_hit   = ien[EN_RX]    & rx_avail;
    assign tx_hit   = ien[EN_TX]    & thr_pend;
    assign ms_hit   = ien[EN_MODEM] & (|msr_delta);

    always_comb begin
        if (line_hit)      id = ID_LINE;
        else if (tmo_hit)  id = ID_TIMEOUT;
        else if (rx_hit)   id = ID_RXDATA;
        else if (tx_hit)   id = ID_THRE;
        else if (ms_hit)   id = ID_MODEM;
        else               id = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ien,
    input  logic [5:0]       line_stat,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             ier_wr,
    input  logic             ier_new_tx,
    output logic [7:0]       iir_q,
    output logic             irq
);
    logic    pend_next;
    logic    rx_avail;
    irq_id_e id;

    uart_irq_thr_track u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .thre       (line_stat[ST_THRE]),
        .en_tx      (ien[EN_TX]),
        .ier_wr     (ier_wr),
        .ier_new_tx (ier_new_tx),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .shown_thre (iir_q[3:0] == ID_THRE),
        .pend_next  (pend_next)
    );

    uart_irq_rx_qual #(.CNT_W(CNT_W)) u_rxq (
        .fifo_en (fifo_en),
        .ready   (line_stat[ST_DR]),
        .count   (rx_count),
        .trig    (rx_trig),
        .avail   (rx_avail)
    );

    uart_irq_rank u_rank (
        .ien       (ien),
        .errs      (line_stat[4:1]),
        .timeout   (rx_timeout),
        .rx_avail  (rx_avail),
        .thr_pend  (pend_next),
        .msr_delta (msr_delta),
        .id        (id)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iir_q <= {4'h0, ID_NONE};
            irq   <= 1'b0;
        end else begin
            iir_q <= {{2{fifo_en}}, 2'b00, id};
            irq   <= (id != ID_NONE);
        end
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ien,
    input logic [5:0] line_stat,
    input logic       fifo_en,
    input logic       rx_timeout,
    input logic       thr_wr,
    input logic [7:0] iir_q,
    input logic       irq
);
    assert_irq_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_q[3:0] != 4'h1));

    assert_fifo_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iir_q[7:6] == {2{$past(fifo_en)}}) && (iir_q[5:4] == 2'b00));

    assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[2] && (|line_stat[4:1])) |=> iir_q[3:0] == 4'h6);

    assert_tmo_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien[0]) |=> iir_q[3:0] != 4'hC);

    assert_thr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> iir_q[3:0] != 4'h2);

    assert_tmo_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[0] && rx_timeout && !(ien[2] && (|line_stat[4:1]))) |=> iir_q[3:0] == 4'hC);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien        (ien),
    .line_stat  (line_stat),
    .fifo_en    (fifo_en),
    .rx_timeout (rx_timeout),
    .thr_wr     (thr_wr),
    .iir_q      (iir_q),
    .irq        (irq)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ien;
    logic [5:0] line_stat;
    logic       fifo_en;
    logic [4:0] rx_count, rx_trig;
    logic       rx_timeout;
    logic [3:0] msr_delta;
    logic       thr_wr, iir_rd, ier_wr, ier_new_tx;
    logic [7:0] iir_q;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .ien(ien), .line_stat(line_stat),
        .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .msr_delta(msr_delta), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .ier_wr(ier_wr), .ier_new_tx(ier_new_tx),
        .iir_q(iir_q), .irq(irq)
    );

    // fields: ien, line_stat, fifo_en, count, trig, timeout, msr_delta, expected byte
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {4'hF, 6'h00, 1'b0, 5'd0,  5'd1, 1'b0, 4'h0, 8'h01}, // nothing pending
        {4'hF, 6'h02, 1'b0, 5'd0,  5'd1, 1'b0, 4'h0, 8'h06}, // R3 overrun
        {4'hB, 6'h03, 1'b0, 5'd0,  5'd1, 1'b0, 4'h0, 8'h04}, // R5 no fifo, R3 masked
        {4'hF, 6'h01, 1'b1, 5'd3,  5'd4, 1'b0, 4'h0, 8'hC1}, // R5 below trigger
        {4'hF, 6'h01, 1'b1, 5'd4,  5'd4, 1'b0, 4'h0, 8'hC4}, // R5 at trigger
        {4'hF, 6'h01, 1'b1, 5'd2,  5'd4, 1'b1, 4'h0, 8'hCC}, // R4 timeout
        {4'hE, 6'h01, 1'b1, 5'd8,  5'd4, 1'b1, 4'h1, 8'hC0}, // R4 gated, R6 modem
        {4'hF, 6'h11, 1'b1, 5'd9,  5'd4, 1'b1, 4'hF, 8'hC6}, // R2 line beats all
        {4'h7, 6'h00, 1'b0, 5'd0,  5'd1, 1'b0, 4'h4, 8'h01}, // R6 disabled
        {4'h8, 6'h00, 1'b0, 5'd0,  5'd1, 1'b0, 4'h2, 8'h00}, // R6 enabled
        {4'hB, 6'h1F, 1'b0, 5'd0,  5'd1, 1'b0, 4'h0, 8'h04}, // R3 disabled
        {4'hF, 6'h01, 1'b1, 5'd16, 5'd14,1'b0, 4'h8, 8'hC4}  // R2 rx beats modem
    };

    task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: iir got=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic check1(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq got=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ien = 4'h0; line_stat = 6'h00; fifo_en = 1'b0; rx_count = '0;
        rx_trig = 5'd1; rx_timeout = 1'b0; msr_delta = 4'h0;
        thr_wr = 1'b0; iir_rd = 1'b0; ier_wr = 1'b0; ier_new_tx = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        step(); step();
        check8("R1", iir_q, 8'h01);
        check1("R1", irq, 1'b0);
        rst_n = 1'b1;
        step();

        // table walk
        for (int i = 0; i < NV; i++) begin
            {ien, line_stat, fifo_en, rx_count, rx_trig, rx_timeout, msr_delta} = VEC[i][36:8];
            step();
            check8($sformatf("R2/R11 vec%0d", i), iir_q, VEC[i][7:0]);
            check1($sformatf("R12 vec%0d", i), irq, VEC[i][3:0] != 4'h1);
        end

        // transmit-empty flag
        idle_inputs();
        ien = 4'hF;
        step();
        check8("R7 idle", iir_q, 8'h01);
        line_stat = 6'h20;                       // empty edge
        step();
        check8("R7", iir_q, 8'h02);
        check1("R12", irq, 1'b1);
        iir_rd = 1'b1;                            // acknowledge while shown
        step();
        iir_rd = 1'b0;
        check8("R9 ack", iir_q, 8'h01);
        ier_wr = 1'b1; ier_new_tx = 1'b1;         // no change of bit 1
        step();
        ier_wr = 1'b0;
        check8("R10 no change", iir_q, 8'h01);
        ier_wr = 1'b1; ier_new_tx = 1'b0;         // disable
        step();
        ier_wr = 1'b0; ien = 4'hD;
        step();
        ier_wr = 1'b1; ier_new_tx = 1'b1;         // re-enable with empty set
        step();
        ier_wr = 1'b0; ien = 4'hF;
        step();
        check8("R10 rearm", iir_q, 8'h02);
        thr_wr = 1'b1; line_stat = 6'h00;         // transmit write
        step();
        thr_wr = 1'b0;
        check8("R8", iir_q, 8'h01);

        // read while a higher code is shown
        line_stat = 6'h22;
        step();
        check8("R9 higher shown", iir_q, 8'h06);
        iir_rd = 1'b1;
        step();
        iir_rd = 1'b0; line_stat = 6'h20;
        step();
        check8("R9 not acked", iir_q, 8'h02);

        // same-cycle transmit write and empty edge
        line_stat = 6'h00;
        step();
        line_stat = 6'h20; thr_wr = 1'b1;
        step();
        thr_wr = 1'b0;
        check8("R8 precedence", iir_q, 8'h01);

        // enable toggle while not empty
        line_stat = 6'h00;
        ier_wr = 1'b1; ier_new_tx = 1'b0;
        step();
        ier_wr = 1'b0; ien = 4'hD;
        step();
        ier_wr = 1'b1; ier_new_tx = 1'b1;
        step();
        ier_wr = 1'b0; ien = 4'hF;
        step();
        check8("R10 not empty", iir_q, 8'h01);
        line_stat = 6'h20;
        step();
        check8("R7 again", iir_q, 8'h02);

        // reset mid-run
        rst_n = 1'b0;
        step();
        check8("R1 mid", iir_q, 8'h01);
        check1("R1 mid", irq, 1'b0);
        rst_n = 1'b1;
        step();
        check8("R7 no edge after reset", iir_q, 8'h01);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule